// File: doc/BRIEF.md
# Hardware-to-Message Interrupt Translator

This block watches a set of wire interrupt lines and turns every level change on any of them into a single-word bus write. The write goes to an address that software has programmed for that line in a downstream interrupt controller. The effect is a wired interrupt delivered as a memory write message. Each line is resynchronised to the block clock, and its edges are detected. A detected edge marks the line as pending, and a round-robin arbiter picks which pending line is served next.

The block has two interfaces. A simple register port lets software program the target address of each channel and read back that channel's status: the synchronised line level, plus a sticky error flag that a failed write response sets and a status read clears. A request/response initiator port issues one write at a time. Each write carries the channel index as its data word. The next write is not issued until the response to the previous one has returned.

Top module: `irq_msg_bridge`

## Requirements
- R1: After reset, `wr_req_valid` is 0, `reg_rdata` is 0, and every target address register reads 0.
- R2: A rising transition on `irq_in[c]` produces exactly one write request. Its `wr_req_addr` equals channel c's programmed address {upper, lower}, and its `wr_req_data` equals c.
- R3: A falling transition on `irq_in[c]` also produces exactly one such write request.
- R4: The register at byte address c*16 + 0x0 holds the lower 32 address bits of channel c. The register at c*16 + 0x4 holds the upper ADDR_W-32 bits, and its higher bits read 0. A read returns its data on `reg_rdata` in the cycle after the access. Accesses with `reg_addr[1:0]` not equal to 0 are ignored.
- R5: The register at c*16 + 0x8 is the status register. Bit 0 is the synchronised level of `irq_in[c]`, bit 1 is the error flag, and bits 31:2 read 0.
- R6: A write response with `wr_rsp_err`=1 sets the error flag of the channel whose write it answers. Any read of that channel's status register clears the flag.
- R7: If an error response and a status read of the same channel fall in the same cycle, the flag ends up set. The read returns the flag's previous value.
- R8: Pending channels are served round-robin. After channel k is granted, the next grant goes to the first pending channel in the order k+1, k+2, and so on, wrapping at NUM_CH. Channel 0 is first after reset.
- R9: At most one write is outstanding. After a request is accepted (`wr_req_valid` and `wr_req_ready` both 1), `wr_req_valid` stays 0 until `wr_rsp_valid` has been seen.
- R10: While `wr_req_valid` is 1 and `wr_req_ready` is 0, the request and its address and data stay unchanged.
- R11: Writes to a status register are ignored. They change neither the error flag nor any other state.
- R12: Several edges on one channel that occur before that channel's write is accepted merge into a single write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_CH | Asynchronous wire interrupt lines |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | REG_AW | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data, valid in the cycle after a read |
| wr_req_valid | output | 1 | Write request present |
| wr_req_ready | input | 1 | Downstream accepts the request |
| wr_req_addr | output | ADDR_W | Target address of the write |
| wr_req_data | output | 32 | Write data (channel index) |
| wr_rsp_valid | input | 1 | Write response present |
| wr_rsp_err | input | 1 | Response reports an error |

## Verification
The embedded assertions check the following on every cycle: the single-outstanding rule, request stability under back-pressure, the rule that a detected edge marks its channel pending, and the error-flag priorities (set wins over a read, a read clears, a status write leaves the flag alone). Other behaviours can only be shown by the bench's scenarios. These are the end-to-end mapping from a line edge to a write carrying the right address and data, the round-robin order including wrap-around, the merging of repeated edges into one write, the register readback widths, and the status values that software actually sees.

// File: rtl/irq_msg_pkg.sv
package irq_msg_pkg;
    typedef enum logic [1:0] {
        BUS_IDLE = 2'd0,
        BUS_REQ  = 2'd1,
        BUS_WAIT = 2'd2
    } bus_state_e;

    localparam logic [1:0] OFF_ADDR_LO = 2'd0;
    localparam logic [1:0] OFF_ADDR_HI = 2'd1;
    localparam logic [1:0] OFF_STATUS  = 2'd2;
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] raw_in,
    output logic [NUM_CH-1:0] level,
    output logic [NUM_CH-1:0] edge_pulse
);
    typedef struct packed {
        logic [NUM_CH-1:0] meta;
        logic [NUM_CH-1:0] sync;
        logic [NUM_CH-1:0] prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = raw_in;
        st_d.sync = st_q.meta;
        st_d.prev = st_q.sync;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level      = st_q.sync;
    assign edge_pulse = st_q.sync ^ st_q.prev;
endmodule

// File: rtl/irq_rr_arb.sv
module irq_rr_arb #(
    parameter int NUM_CH = 4,
    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] req,
    input  logic              take,
    output logic              gnt_any,
    output logic [IDX_W-1:0]  gnt_idx
);
    logic [IDX_W-1:0] last_d, last_q;

    always_comb begin
        gnt_any = 1'b0;
        gnt_idx = '0;
        for (int k = NUM_CH; k >= 1; k--) begin
            int c;
            c = int'(last_q) + k;
            if (c >= NUM_CH) c = c - NUM_CH;
            if (req[c]) begin
                gnt_any = 1'b1;
                gnt_idx = IDX_W'(c);
            end
        end
        last_d = (take && gnt_any) ? gnt_idx : last_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= IDX_W'(NUM_CH - 1);
        else        last_q <= last_d;
    end

    // R8: a grant never goes to a channel that is not requesting
    a_r8_grant_requested: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_any |-> req[gnt_idx]);
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
    import irq_msg_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 40,
    parameter int REG_AW = 8,
    localparam int HI_W  = ADDR_W - 32,
    localparam int CH_AW = REG_AW - 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_valid,
    input  logic                          reg_write,
    input  logic [REG_AW-1:0]             reg_addr,
    input  logic [31:0]                   reg_wdata,
    output logic [31:0]                   reg_rdata,
    input  logic [NUM_CH-1:0]             level,
    input  logic [NUM_CH-1:0]             err_set,
    output logic [NUM_CH-1:0][ADDR_W-1:0] tgt_addr
);
    typedef struct packed {
        logic [NUM_CH-1:0][31:0]   lo;
        logic [NUM_CH-1:0][HI_W-1:0] hi;
        logic [NUM_CH-1:0]         err;
        logic [31:0]               rdata;
    } rf_st_t;

    rf_st_t st_d, st_q;

    logic             hit;
    logic [CH_AW-1:0] ch_sel;
    logic [1:0]       off;
    logic [NUM_CH-1:0] sel, wr_lo, wr_hi, wr_stat, rd_stat;

    assign hit    = reg_valid && (reg_addr[1:0] == 2'b00);
    assign ch_sel = reg_addr[REG_AW-1:4];
    assign off    = reg_addr[3:2];

    for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
        assign sel[i]     = hit && (ch_sel == CH_AW'(i));
        assign wr_lo[i]   = sel[i] && reg_write && (off == OFF_ADDR_LO);
        assign wr_hi[i]   = sel[i] && reg_write && (off == OFF_ADDR_HI);
        assign wr_stat[i] = sel[i] && reg_write && (off == OFF_STATUS);
        assign rd_stat[i] = sel[i] && !reg_write && (off == OFF_STATUS);
        assign tgt_addr[i] = {st_q.hi[i], st_q.lo[i]};
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_CH; i++) begin
            if (err_set[i])      st_d.err[i] = 1'b1;
            else if (rd_stat[i]) st_d.err[i] = 1'b0;
            if (wr_lo[i]) st_d.lo[i] = reg_wdata;
            if (wr_hi[i]) st_d.hi[i] = reg_wdata[HI_W-1:0];
        end
        if (hit && !reg_write) begin
            st_d.rdata = '0;
            for (int i = 0; i < NUM_CH; i++) begin
                if (sel[i]) begin
                    case (off)
                        OFF_ADDR_LO: st_d.rdata = st_q.lo[i];
                        OFF_ADDR_HI: st_d.rdata = 32'(st_q.hi[i]);
                        OFF_STATUS:  st_d.rdata = {30'd0, st_q.err[i], level[i]};
                        default:     st_d.rdata = '0;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reg_rdata = st_q.rdata;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        a_r7_set_beats_read: assert property (@(posedge clk) disable iff (!rst_n)
            err_set[i] |=> st_q.err[i]);
        a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_stat[i] && !err_set[i]) |=> !st_q.err[i]);
        a_r11_status_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_stat[i] && !err_set[i]) |=> (st_q.err[i] == $past(st_q.err[i])));
    end
endmodule

// File: rtl/irq_msg_bridge.sv
module irq_msg_bridge
    import irq_msg_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 40,
    parameter int REG_AW = 8,
    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] irq_in,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              wr_req_valid,
    input  logic              wr_req_ready,
    output logic [ADDR_W-1:0] wr_req_addr,
    output logic [31:0]       wr_req_data,
    input  logic              wr_rsp_valid,
    input  logic              wr_rsp_err
);
    typedef struct packed {
        bus_state_e        state;
        logic [IDX_W-1:0]  cur;
        logic [ADDR_W-1:0] addr;
        logic [NUM_CH-1:0] pending;
    } br_st_t;

    br_st_t st_d, st_q;

    logic [NUM_CH-1:0]             level, edge_pulse, err_set;
    logic [NUM_CH-1:0][ADDR_W-1:0] tgt_addr;
    logic                          gnt_any, take;
    logic [IDX_W-1:0]              gnt_idx;

    irq_edge_sync #(.NUM_CH(NUM_CH)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw_in(irq_in),
        .level(level), .edge_pulse(edge_pulse)
    );

    irq_rr_arb #(.NUM_CH(NUM_CH)) u_arb (
        .clk(clk), .rst_n(rst_n), .req(st_q.pending), .take(take),
        .gnt_any(gnt_any), .gnt_idx(gnt_idx)
    );

    irq_regfile #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .REG_AW(REG_AW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .level(level), .err_set(err_set), .tgt_addr(tgt_addr)
    );

    always_comb begin
        st_d    = st_q;
        take    = 1'b0;
        err_set = '0;
        case (st_q.state)
            BUS_IDLE: begin
                if (gnt_any) begin
                    take       = 1'b1;
                    st_d.cur   = gnt_idx;
                    st_d.addr  = tgt_addr[gnt_idx];
                    st_d.state = BUS_REQ;
                end
            end
            BUS_REQ: begin
                if (wr_req_ready) begin
                    st_d.pending[st_q.cur] = 1'b0;
                    st_d.state             = BUS_WAIT;
                end
            end
            BUS_WAIT: begin
                if (wr_rsp_valid) begin
                    err_set[st_q.cur] = wr_rsp_err;
                    st_d.state        = BUS_IDLE;
                end
            end
            default: st_d.state = BUS_IDLE;
        endcase
        // a fresh edge outranks the clear from an acceptance
        st_d.pending = st_d.pending | edge_pulse;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= BUS_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_req_valid = (st_q.state == BUS_REQ);
    assign wr_req_addr  = st_q.addr;
    assign wr_req_data  = 32'(st_q.cur);

    // R9: accepted write closes the request until its response comes back
    a_r9_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_valid && wr_req_ready) |=> !wr_req_valid);
    // R10: stalled request keeps its contents
    a_r10_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_valid && !wr_req_ready) |=>
            (wr_req_valid && $stable(wr_req_addr) && $stable(wr_req_data)));
    for (genvar i = 0; i < NUM_CH; i++) begin : g_pend
        // R2 and R3: either edge direction marks the channel pending
        a_r3_edge_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
            edge_pulse[i] |=> st_q.pending[i]);
    end
endmodule

// File: tb/tb_irq_msg_bridge.sv
module tb_irq_msg_bridge;
    localparam int NCH = 4;
    localparam int AW  = 40;
    localparam int RAW = 8;

    typedef struct {
        logic [AW-1:0] addr;
        logic [31:0]   data;
        string         req;
    } exp_t;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] irq_in = '0;
    logic           reg_valid = 1'b0, reg_write = 1'b0;
    logic [RAW-1:0] reg_addr = '0;
    logic [31:0]    reg_wdata = '0;
    logic [31:0]    reg_rdata;
    logic           wr_req_valid, wr_req_ready = 1'b0;
    logic [AW-1:0]  wr_req_addr;
    logic [31:0]    wr_req_data;
    logic           wr_rsp_valid = 1'b0, wr_rsp_err = 1'b0;

    int   n_cmp = 0, n_bad = 0;
    bit   auto_en = 1'b1, err_mode = 1'b0, finished = 1'b0;
    exp_t exp_q[$];
    logic [AW-1:0] cfg [NCH];

    always #2.5 clk = ~clk;

    irq_msg_bridge #(.NUM_CH(NCH), .ADDR_W(AW), .REG_AW(RAW)) dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .wr_req_valid(wr_req_valid), .wr_req_ready(wr_req_ready),
        .wr_req_addr(wr_req_addr), .wr_req_data(wr_req_data),
        .wr_rsp_valid(wr_rsp_valid), .wr_rsp_err(wr_rsp_err)
    );

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic push_exp(int ch, string req);
        exp_t e;
        e.addr = cfg[ch];
        e.data = 32'(ch);
        e.req  = req;
        exp_q.push_back(e);
    endtask

    // driver: toggle a set of lines together, queue one expected write per channel in given order
    task automatic toggle(logic [NCH-1:0] mask, int order[$], string req);
        @(negedge clk);
        irq_in = irq_in ^ mask;
        foreach (order[k]) push_exp(order[k], req);
    endtask

    // monitor comparison of a request about to be accepted
    task automatic compare_req();
        exp_t e;
        if (exp_q.size() == 0) begin
            check(1'b0, "R2", {24'd0, wr_req_addr}, 64'd0);
        end else begin
            e = exp_q.pop_front();
            check(wr_req_addr == e.addr, e.req, 64'(wr_req_addr), 64'(e.addr));
            check(wr_req_data == e.data, e.req, 64'(wr_req_data), 64'(e.data));
        end
    endtask

    task automatic reg_rd(int a, output logic [31:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b0; reg_addr = RAW'(a);
        @(negedge clk);
        reg_valid = 1'b0;
        d = reg_rdata;
    endtask

    task automatic reg_wr(int a, logic [31:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = RAW'(a); reg_wdata = d;
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (12) @(negedge clk);
    endtask

    // responder and monitor
    initial begin
        forever begin
            @(negedge clk);
            if (auto_en && rst_n && wr_req_valid) begin
                compare_req();
                wr_req_ready = 1'b1;
                @(negedge clk);
                wr_req_ready = 1'b0;
                repeat (2) @(negedge clk);
                wr_rsp_valid = 1'b1; wr_rsp_err = err_mode;
                @(negedge clk);
                wr_rsp_valid = 1'b0; wr_rsp_err = 1'b0;
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        for (int c = 0; c < NCH; c++) cfg[c] = {8'(8'h0C + c), 32'h1000_0100 + 32'(c * 16)};
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(wr_req_valid == 1'b0, "R1", 64'(wr_req_valid), 0);
        check(reg_rdata == 32'd0, "R1", 64'(reg_rdata), 0);
        reg_rd(2 * 16 + 0, d);
        check(d == 32'd0, "R1", 64'(d), 0);

        // R4: program and read back
        for (int c = 0; c < NCH; c++) begin
            reg_wr(c * 16 + 0, cfg[c][31:0]);
            reg_wr(c * 16 + 4, 32'(cfg[c][AW-1:32]));
        end
        reg_rd(1 * 16 + 0, d);
        check(d == cfg[1][31:0], "R4", 64'(d), 64'(cfg[1][31:0]));
        reg_rd(1 * 16 + 4, d);
        check(d == 32'(cfg[1][AW-1:32]), "R4", 64'(d), 64'(cfg[1][AW-1:32]));
        reg_wr(3 * 16 + 4, 32'hFFFF_FF5A);
        reg_rd(3 * 16 + 4, d);
        check(d == 32'h5A, "R4", 64'(d), 64'h5A);
        reg_wr(3 * 16 + 4 + 1, 32'h0000_0077); // misaligned, ignored
        reg_rd(3 * 16 + 4, d);
        check(d == 32'h5A, "R4", 64'(d), 64'h5A);
        reg_wr(3 * 16 + 4, 32'(cfg[3][AW-1:32]));

        // R2: rising edge on channel 0
        toggle(4'b0001, '{0}, "R2");
        drain();
        // R5: level visible in status
        reg_rd(0 * 16 + 8, d);
        check(d == 32'h1, "R5", 64'(d), 1);
        // R3: falling edge on channel 0
        toggle(4'b0001, '{0}, "R3");
        drain();
        reg_rd(0 * 16 + 8, d);
        check(d == 32'h0, "R5", 64'(d), 0);

        // R8: last grant ch2, then ch0,1,3 together -> order 3,0,1
        toggle(4'b0100, '{2}, "R8");
        drain();
        toggle(4'b1011, '{3, 0, 1}, "R8");
        drain();

        // R12: two edges on ch1 while its write is stalled merge into one
        auto_en = 1'b0;
        toggle(4'b0010, '{1}, "R12");
        repeat (10) @(negedge clk);
        check(wr_req_valid == 1'b1, "R10", 64'(wr_req_valid), 1);
        toggle(4'b0010, '{}, "R12");
        repeat (10) @(negedge clk);
        auto_en = 1'b1;
        drain();
        repeat (20) @(negedge clk);
        check(wr_req_valid == 1'b0, "R12", 64'(wr_req_valid), 0);

        // R6: error response on ch2 (ch2 line goes 1 -> 0)
        err_mode = 1'b1;
        toggle(4'b0100, '{2}, "R6");
        drain();
        err_mode = 1'b0;
        // R11: status write does not clear the flag
        reg_wr(2 * 16 + 8, 32'h0);
        reg_rd(2 * 16 + 8, d);
        check(d == 32'h2, "R11", 64'(d), 2);
        reg_rd(2 * 16 + 8, d);
        check(d == 32'h0, "R6", 64'(d), 0);
        reg_wr(2 * 16 + 8, 32'hFFFF_FFFF);
        reg_rd(2 * 16 + 8, d);
        check(d == 32'h0, "R11", 64'(d), 0);

        // R7: error response and status read of ch3 in the same cycle
        auto_en = 1'b0;
        toggle(4'b1000, '{3}, "R7");
        while (!wr_req_valid) @(negedge clk);
        compare_req();
        wr_req_ready = 1'b1;
        @(negedge clk);
        wr_req_ready = 1'b0;
        check(wr_req_valid == 1'b0, "R9", 64'(wr_req_valid), 0);
        repeat (3) @(negedge clk);
        check(wr_req_valid == 1'b0, "R9", 64'(wr_req_valid), 0);
        wr_rsp_valid = 1'b1; wr_rsp_err = 1'b1;
        reg_valid = 1'b1; reg_write = 1'b0; reg_addr = RAW'(3 * 16 + 8);
        @(negedge clk);
        wr_rsp_valid = 1'b0; wr_rsp_err = 1'b0; reg_valid = 1'b0;
        check(reg_rdata == 32'h0, "R7", 64'(reg_rdata), 0);
        reg_rd(3 * 16 + 8, d);
        check(d == 32'h2, "R7", 64'(d), 2);
        reg_rd(3 * 16 + 8, d);
        check(d == 32'h0, "R6", 64'(d), 0);
        auto_en = 1'b1;

        repeat (10) @(negedge clk);
        check(exp_q.size() == 0, "R2", 64'(exp_q.size()), 0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule